// File: doc/BRIEF.md
# Flash Status Register and Block-Protect Guard

This block holds the volatile view of a serial flash device's status register together with the top/bottom select bit of its configuration register. It takes already-decoded opcodes with their data bytes, a busy indication from the array controller and the level of the write-protect pin. It then updates the write-enable latch, the protect field, the quad-enable bit and the status-write-disable bit, and answers register read commands with a byte one cycle later.

A second, purely combinational path takes a 24-bit program or erase address and reports whether its 64KB block lies in the region the block-protect field and the top/bottom bit guard. The array controller consults this flag before it starts an operation. Nonvolatile bits are flip-flops loaded from parameter presets on reset. Once the top/bottom bit is set it cannot be cleared by any command.

Top module: `flash_status_guard`

## Requirements
- R1: After reset, `status_o` equals the preset (default 00h) with bit 0 following `busy`, `config_o` is 00h and `rd_valid` is 0.
- R2: Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears it.
- R3: Opcode 05h returns the status byte on `rd_data` with `rd_valid` high in the next cycle. The byte layout is bit 0 busy, bit 1 write-enable latch, bits [5:2] protect field, bit 6 quad enable and bit 7 status-write disable. Opcode 15h returns the configuration byte, with the top/bottom bit in bit 3 and all other bits 0.
- R4: Opcode 01h has no effect unless the write-enable latch is 1 and `busy` is 0.
- R5: An accepted 01h loads status bits [7:2] from `cmd_data[7:2]`, ignores `cmd_data[1:0]` and clears the write-enable latch.
- R6: While status bit 7 is 1 and `wp_n` is 0, opcode 01h is ignored entirely, and the latch stays set. With `wp_n` high the write is accepted.
- R7: An accepted 01h with `cmd_data[11]` (configuration bit 3) at 1 sets the top/bottom bit. A later write with that bit at 0 leaves it at 1.
- R8: A protect field of 0 leaves every address unprotected.
- R9: With the top/bottom bit at 0 and a protect field P from 1 to 9, the blocks `addr[23:16] >= 256 - 2^(P-1)` are protected and no others.
- R10: With the top/bottom bit at 1 and P from 1 to 9, the blocks `addr[23:16] < 2^(P-1)` are protected and no others.
- R11: A protect field of 10 to 15 protects every address.
- R12: `prot` follows `addr` and the stored state in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the power-on presets |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Opcode |
| cmd_data | input | 16 | Write data: [7:0] status byte, [15:8] configuration byte |
| busy | input | 1 | Array operation in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | 24 | Program or erase target address |
| status_o | output | 8 | Current status byte |
| config_o | output | 8 | Current configuration byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read opcode |
| rd_data | output | 8 | Register read data |
| prot | output | 1 | Address falls in the protected region |

## Verification
A wrong latch or protect value reaches the ports at once. `status_o` shows it on the next clock edge after the command that caused it. `prot` shows it in the same cycle for any address near a boundary. A top/bottom bit that could be cleared, or a write that slipped past the write-protect pin, only shows after a later write and read-back. For that reason the directed scenarios always follow such an attempt with a status and configuration read. The boundary sweep tests the blocks just below and just above each region edge, for every protect value and both ends of the array.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W = 24,
  parameter int BLK_W = 8,
  parameter logic [7:0] PRESET_STATUS = 8'h00,
  parameter logic PRESET_TB = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [15:0]       cmd_data,
  input  logic              busy,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_o,
  output logic [7:0]        config_o,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              prot
);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_RDCR = 8'h15;
  localparam int BLK_LSB = ADDR_W - BLK_W;
  localparam logic [BLK_W:0] NUM_BLK = {1'b1, {BLK_W{1'b0}}};
  localparam logic [BLK_W:0] ONE_BLK = {{BLK_W{1'b0}}, 1'b1};
  localparam logic [3:0] BP_FULL = 4'(BLK_W + 1);

  logic       wel;
  logic [3:0] bp;
  logic       qe;
  logic       srwd;
  logic       tb;

  wire is_op = cmd_valid;
  wire wr_ok = is_op && cmd_op == OP_WRSR && wel && !busy && !(srwd && !wp_n);

  assign status_o = {srwd, qe, bp, wel, busy};
  assign config_o = {4'b0, tb, 3'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      bp   <= PRESET_STATUS[5:2];
      qe   <= PRESET_STATUS[6];
      srwd <= PRESET_STATUS[7];
      tb   <= PRESET_TB;
    end else if (wr_ok) begin
      wel  <= 1'b0;
      bp   <= cmd_data[5:2];
      qe   <= cmd_data[6];
      srwd <= cmd_data[7];
      tb   <= tb | cmd_data[11];
    end else if (is_op && cmd_op == OP_WREN) begin
      wel <= 1'b1;
    end else if (is_op && cmd_op == OP_WRDI) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= is_op && (cmd_op == OP_RDSR || cmd_op == OP_RDCR);
      if (is_op && cmd_op == OP_RDSR) rd_data <= status_o;
      else if (is_op && cmd_op == OP_RDCR) rd_data <= config_o;
    end
  end

  logic [BLK_W:0] span;
  logic [BLK_W:0] blk;

  assign blk = {1'b0, addr[ADDR_W-1:BLK_LSB]};

  always_comb begin
    if (bp == 4'd0) span = '0;
    else if (bp >= BP_FULL) span = NUM_BLK;
    else span = ONE_BLK << (bp - 4'd1);
  end

  assign prot = (span != '0) && (tb ? (blk < span) : (blk >= NUM_BLK - span));
endmodule

// File: rtl/flash_status_guard_chk.sv
module flash_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       busy,
  input logic       wp_n,
  input logic [7:0] status_o,
  input logic [7:0] config_o,
  input logic       prot
);
  AST_WRITE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o[7:2]) |-> $past(cmd_valid && cmd_op == 8'h01 && status_o[1] && !busy)); // R4
  AST_WRITE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h01 && status_o[1] && !busy && !(status_o[7] && !wp_n)) |=> !status_o[1]); // R5
  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h01 && status_o[7] && !wp_n) |=> ($stable(status_o[7:1]) && $stable(config_o))); // R6
  AST_TB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(config_o[3]) |-> config_o[3]); // R7
  AST_BP_ZERO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5:2] == 4'd0) |-> !prot); // R8
  AST_BP_HIGH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5:2] >= 4'd10) |-> prot); // R11
endmodule

bind flash_status_guard flash_status_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .wp_n(wp_n), .status_o(status_o), .config_o(config_o), .prot(prot)
);

// File: tb/flash_status_guard_test.sv
module flash_status_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_data = 16'h0000;
  logic        busy = 1'b0;
  logic        wp_n = 1'b1;
  logic [23:0] addr = 24'h0;
  logic [7:0]  status_o, config_o, rd_data;
  logic        rd_valid, prot;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_status_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .wp_n(wp_n), .addr(addr),
    .status_o(status_o), .config_o(config_o), .rd_valid(rd_valid),
    .rd_data(rd_data), .prot(prot)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00; cmd_data = 16'h0;
  endtask

  task automatic read_reg(input logic [7:0] op, input string req, input int exp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00;
    chk({req, " rd_valid"}, rd_valid, 1);
    chk({req, " rd_data"}, rd_data, exp);
  endtask

  task automatic write_sr(input logic [7:0] s, input logic [7:0] c);
    issue(8'h06, 16'h0);
    issue(8'h01, {c, s});
  endtask

  function automatic int exp_prot(input int bp, input int tb, input int blk);
    int n;
    if (bp == 0) return 0;
    n = (bp >= 9) ? 256 : (1 << (bp - 1));
    if (tb != 0) return (blk < n) ? 1 : 0;
    return (blk >= 256 - n) ? 1 : 0;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 status", status_o, 8'h00);
    chk("R1 config", config_o, 8'h00);
    chk("R1 rd_valid", rd_valid, 0);
    busy = 1'b1; #1;
    chk("R1 busy bit", status_o, 8'h01);
    busy = 1'b0;
  endtask

  task automatic t_latch();
    issue(8'h06, 16'h0);
    chk("R2 wren", status_o[1], 1);
    read_reg(8'h05, "R3 rdsr", 8'h02);
    issue(8'h04, 16'h0);
    chk("R2 wrdi", status_o[1], 0);
    read_reg(8'h15, "R3 rdcr", 8'h00);
  endtask

  task automatic t_gate();
    issue(8'h01, 16'h003C);
    read_reg(8'h05, "R4 no wel", 8'h00);
    issue(8'h06, 16'h0);
    busy = 1'b1;
    issue(8'h01, 16'h003C);
    chk("R4 busy", status_o, 8'h03);
    busy = 1'b0;
    issue(8'h01, 16'h007F);
    read_reg(8'h05, "R5 write", 8'h7C);
    write_sr(8'h03, 8'h00);
    chk("R5 low bits", status_o, 8'h00);
  endtask

  task automatic t_lock();
    write_sr(8'h84, 8'h00);
    chk("R6 set srwd", status_o, 8'h84);
    wp_n = 1'b0;
    issue(8'h06, 16'h0);
    issue(8'h01, 16'h0800);
    chk("R6 locked", status_o, 8'h86);
    read_reg(8'h15, "R6 cfg kept", 8'h00);
    wp_n = 1'b1;
    issue(8'h01, 16'h0000);
    chk("R6 pin high", status_o, 8'h00);
  endtask

  task automatic sweep(input int tb, input string req);
    for (int b = 0; b < 16; b++) begin
      write_sr(8'(b << 2), 8'(tb << 3));
      for (int k = 0; k < 10; k++) begin
        int blk;
        int n;
        n = (b == 0) ? 1 : ((b >= 9) ? 256 : (1 << (b - 1)));
        case (k)
          0: blk = 0;
          1: blk = 255;
          2: blk = n - 1;
          3: blk = n & 255;
          4: blk = (256 - n) & 255;
          5: blk = (255 - n) & 255;
          6: blk = 128;
          7: blk = 127;
          8: blk = 1;
          default: blk = 254;
        endcase
        addr = {8'(blk), 16'hA5C3};
        #1;
        chk(req, prot, exp_prot(b, tb, blk));
      end
    end
  endtask

  task automatic t_top();
    sweep(0, "R8 R9 R11 R12 top");
  endtask

  task automatic t_tb();
    write_sr(8'h00, 8'h08);
    read_reg(8'h15, "R7 set", 8'h08);
    write_sr(8'h00, 8'h00);
    read_reg(8'h15, "R7 sticky", 8'h08);
    sweep(1, "R10 R11 bottom");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_gate();
    t_lock();
    t_top();
    t_tb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule